// File: doc/BRIEF.md
# Scatter-Gather Link List Walker

This block drives the memory side of one data direction of a serial peripheral controller. It is started with a two-bit data-mode code. In the two modes that do not use memory, it finishes at once and makes no request. In contiguous mode it treats a single buffer address and byte length as one segment. In list mode it reads 8-byte link entries from memory, one at a time, starting at a list base address. Each entry describes one buffer segment.

Each segment goes to a DMA data port as a series of chunks. A chunk is at most `MAX_CHUNK` bytes and carries the address of its first byte. The walker reads the next link entry only after every byte of the current segment has been accepted. It stops after the entry that carries the end flag. If that entry also carries the ring flag, the walker goes back to the start of the list. It stops with an error flag when it reads an entry that is not valid or that is longer than the largest segment allowed.

Entry reads and chunk transfers each use a plain request/acknowledge pair. The request is held until the acknowledge arrives. For an entry read, the data comes back in the same cycle as the acknowledge.

Top module: `sg_link_walker`

## Requirements
- R1: After reset, `busy`, `done`, `irqPulse`, `descReq`, `dataReq`, `errInvalid` and `errLength` are all low.
- R2: A start with mode code 0 (none) or 1 (programmed I/O) makes no entry read and no chunk request. `done` is high for exactly the one cycle that follows the clock edge which samples `start`, and `busy` is low in the cycle after that.
- R3: A start with mode code 2 (contiguous) sends the `bufAddr`/`bufLen` segment to the data port and makes no entry read.
- R4: A start with mode code 3 (list) reads its first entry at `listBase` with bits 2:0 forced to zero, and each later entry at the previous entry's address plus 8. The 64-bit `descData` holds the entry's first word in bits 31:0 and the buffer address in bits 63:32. In the first word, bit 0 is valid, bit 1 is end of chain, bit 2 is interrupt request, bits 5:3 are the action code, bit 6 is ring, bit 7 is unused, and bits 31:8 are the byte length.
- R5: A segment goes out as chunks of `MAX_CHUNK` bytes, with a smaller final chunk for any remainder. Each chunk address is the previous chunk's address plus the previous chunk's length.
- R6: No entry read is issued while any byte of the current segment is still waiting to be accepted, and `descReq` and `dataReq` are never high together.
- R7: An entry with length zero produces no chunk request, and the walker moves on to the next entry.
- R8: After the segment of an end-of-chain entry without the ring flag, `done` pulses for one cycle and no further entry is read.
- R9: Reading an entry whose valid bit is clear sets `errInvalid`, produces no chunk request for that entry, and ends the walk with a `done` pulse. Both error flags stay set until the next accepted start clears them.
- R10: An entry or contiguous buffer longer than `MAX_SEG` bytes (0x100000) sets `errLength`, produces no chunk request, and ends the walk.
- R11: When an end-of-chain entry carries the ring flag, the next entry read is at the list base again, and the walk does not end.
- R12: `irqPulse` is high for one cycle after the last chunk of a segment whose interrupt bit is set has been accepted, and it never goes high for other segments.
- R13: While `dataReq` is high without `dataAck`, it stays high and `dataAddr` and `dataLen` hold their values. `dataAction` carries the action code of the current entry.
- R14: A `start` pulse while `busy` is high has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| dataMode | input | 2 | 0 none, 1 programmed I/O, 2 contiguous, 3 list |
| listBase | input | 32 | Address of the first link entry |
| bufAddr | input | 32 | Buffer address in contiguous mode |
| bufLen | input | 24 | Buffer byte length in contiguous mode |
| descReq | output | 1 | Entry read request |
| descAddr | output | 32 | Entry address |
| descAck | input | 1 | Entry read acknowledge, with data |
| descData | input | 64 | Entry contents |
| dataReq | output | 1 | Chunk request to the DMA data port |
| dataAddr | output | 32 | First byte address of the chunk |
| dataLen | output | CHUNK_W | Chunk byte count |
| dataAction | output | 3 | Action code of the current entry |
| dataAck | input | 1 | Chunk accepted |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| irqPulse | output | 1 | One-cycle interrupt-segment completion pulse |
| errInvalid | output | 1 | Sticky flag: an invalid entry was read |
| errLength | output | 1 | Sticky flag: a segment was too long |

## Verification
A wrong entry pointer shows up at the next entry read as a wrong `descAddr`. This is visible one cycle after the previous segment's last byte is accepted. A wrong byte counter shows up at the data port. The chunk sizes no longer add up to the entry length, or a read is issued before the segment has been fully sent. The bench logs every request in order, so such a fault appears as a mismatch at the point it first happens. A flag decoded from the wrong bit shows up as a missing or extra `irqPulse` or `done`, or as a walk that wraps or stops when it should not. Each of these is visible within a few cycles of the segment in question.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 24;
  localparam int ENTRY_BYTES = 8;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_PIO  = 2'd1,
    MODE_MEM  = 2'd2,
    MODE_LIST = 2'd3
  } dataMode_e;

  // one-cycle commands from control to datapath
  typedef struct packed {
    logic clearErr;
    logic loadList;
    logic loadFlat;
    logic loadEntry;
    logic stepEntry;
    logic rewind;
    logic consume;
    logic setInvErr;
    logic setLenErr;
  } walkStb_t;
endpackage

// File: rtl/sgw_datapath.sv
module sgw_datapath
  import sgw_pkg::*;
#(
  parameter int MAX_SEG   = 32'h0010_0000,
  parameter int MAX_CHUNK = 64,
  parameter int CHUNK_W   = $clog2(MAX_CHUNK + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkStb_t            stb,
  input  logic [WORD_W-1:0]   listBase,
  input  logic [WORD_W-1:0]   bufAddr,
  input  logic [LEN_W-1:0]    bufLen,
  input  logic [2*WORD_W-1:0] descData,
  output logic [WORD_W-1:0]   entryAddr,
  output logic [WORD_W-1:0]   segAddr,
  output logic [CHUNK_W-1:0]  chunkLen,
  output logic [2:0]          segAction,
  output logic                remZero,
  output logic                entryValid,
  output logic                entryTooLong,
  output logic                lastFlag,
  output logic                ringFlag,
  output logic                irqFlag,
  output logic                errInvalid,
  output logic                errLength
);
  localparam logic [LEN_W-1:0] CHUNK_CAP = LEN_W'(MAX_CHUNK);
  localparam logic [LEN_W-1:0] SEG_CAP   = LEN_W'(MAX_SEG);

  logic [WORD_W-1:0] baseQ;
  logic [LEN_W-1:0]  remQ;
  logic              unusedBits;

  assign unusedBits = ^{descData[7], listBase[2:0]};

  assign remZero      = (remQ == '0);
  assign entryTooLong = (remQ > SEG_CAP);
  assign chunkLen     = (remQ > CHUNK_CAP) ? CHUNK_W'(MAX_CHUNK) : remQ[CHUNK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ      <= '0;
      entryAddr  <= '0;
      segAddr    <= '0;
      remQ       <= '0;
      segAction  <= '0;
      entryValid <= 1'b0;
      lastFlag   <= 1'b0;
      ringFlag   <= 1'b0;
      irqFlag    <= 1'b0;
      errInvalid <= 1'b0;
      errLength  <= 1'b0;
    end else begin
      if (stb.clearErr) begin
        errInvalid <= 1'b0;
        errLength  <= 1'b0;
      end
      if (stb.loadList) begin
        baseQ     <= {listBase[WORD_W-1:3], 3'b000};
        entryAddr <= {listBase[WORD_W-1:3], 3'b000};
      end
      if (stb.loadFlat) begin
        segAddr    <= bufAddr;
        remQ       <= bufLen;
        segAction  <= '0;
        entryValid <= 1'b1;
        lastFlag   <= 1'b1;
        ringFlag   <= 1'b0;
        irqFlag    <= 1'b0;
      end
      if (stb.loadEntry) begin
        entryValid <= descData[0];
        lastFlag   <= descData[1];
        irqFlag    <= descData[2];
        segAction  <= descData[5:3];
        ringFlag   <= descData[6];
        remQ       <= descData[31:8];
        segAddr    <= descData[63:32];
      end
      if (stb.stepEntry) entryAddr <= entryAddr + WORD_W'(ENTRY_BYTES);
      if (stb.rewind)    entryAddr <= baseQ;
      if (stb.consume) begin
        segAddr <= segAddr + WORD_W'(chunkLen);
        remQ    <= remQ - LEN_W'(chunkLen);
      end
      if (stb.setInvErr) errInvalid <= 1'b1;
      if (stb.setLenErr) errLength  <= 1'b1;
    end
  end
endmodule

// File: rtl/sgw_control.sv
module sgw_control
  import sgw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] dataMode,
  input  logic       descAck,
  input  logic       dataAck,
  input  logic       remZero,
  input  logic       entryValid,
  input  logic       entryTooLong,
  input  logic       lastFlag,
  input  logic       ringFlag,
  input  logic       irqFlag,
  output walkStb_t   stb,
  output logic       descReq,
  output logic       dataReq,
  output logic       busy,
  output logic       done,
  output logic       irqPulse
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_XFER, S_FINISH} walkState_e;

  walkState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    stb      = '0;
    descReq  = 1'b0;
    dataReq  = 1'b0;
    irqPulse = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (start) begin
          stb.clearErr = 1'b1;
          unique case (dataMode_e'(dataMode))
            MODE_MEM: begin
              stb.loadFlat = 1'b1;
              stateD = S_CHECK;
            end
            MODE_LIST: begin
              stb.loadList = 1'b1;
              stateD = S_FETCH;
            end
            default: stateD = S_FINISH;
          endcase
        end
      end
      S_FETCH: begin
        descReq = 1'b1;
        if (descAck) begin
          stb.loadEntry = 1'b1;
          stateD = S_CHECK;
        end
      end
      S_CHECK: begin
        if (!entryValid) begin
          stb.setInvErr = 1'b1;
          stateD = S_FINISH;
        end else if (entryTooLong) begin
          stb.setLenErr = 1'b1;
          stateD = S_FINISH;
        end else begin
          stateD = S_XFER;
        end
      end
      S_XFER: begin
        if (remZero) begin
          irqPulse = irqFlag;
          if (lastFlag && !ringFlag) begin
            stateD = S_FINISH;
          end else if (lastFlag) begin
            stb.rewind = 1'b1;
            stateD = S_FETCH;
          end else begin
            stb.stepEntry = 1'b1;
            stateD = S_FETCH;
          end
        end else begin
          dataReq = 1'b1;
          stb.consume = dataAck;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  assign busy = (stateQ != S_IDLE);
  assign done = (stateQ == S_FINISH);
endmodule

// File: rtl/sg_link_walker.sv
module sg_link_walker
  import sgw_pkg::*;
#(
  parameter int MAX_SEG   = 32'h0010_0000,
  parameter int MAX_CHUNK = 64,
  parameter int CHUNK_W   = $clog2(MAX_CHUNK + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [1:0]         dataMode,
  input  logic [31:0]        listBase,
  input  logic [31:0]        bufAddr,
  input  logic [23:0]        bufLen,
  output logic               descReq,
  output logic [31:0]        descAddr,
  input  logic               descAck,
  input  logic [63:0]        descData,
  output logic               dataReq,
  output logic [31:0]        dataAddr,
  output logic [CHUNK_W-1:0] dataLen,
  output logic [2:0]         dataAction,
  input  logic               dataAck,
  output logic               busy,
  output logic               done,
  output logic               irqPulse,
  output logic               errInvalid,
  output logic               errLength
);
  walkStb_t stb;
  logic remZero, entryValid, entryTooLong, lastFlag, ringFlag, irqFlag;

  sgw_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .dataMode(dataMode),
    .descAck(descAck), .dataAck(dataAck), .remZero(remZero),
    .entryValid(entryValid), .entryTooLong(entryTooLong),
    .lastFlag(lastFlag), .ringFlag(ringFlag), .irqFlag(irqFlag),
    .stb(stb), .descReq(descReq), .dataReq(dataReq), .busy(busy),
    .done(done), .irqPulse(irqPulse)
  );

  sgw_datapath #(.MAX_SEG(MAX_SEG), .MAX_CHUNK(MAX_CHUNK), .CHUNK_W(CHUNK_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .listBase(listBase),
    .bufAddr(bufAddr), .bufLen(bufLen), .descData(descData),
    .entryAddr(descAddr), .segAddr(dataAddr), .chunkLen(dataLen),
    .segAction(dataAction), .remZero(remZero), .entryValid(entryValid),
    .entryTooLong(entryTooLong), .lastFlag(lastFlag), .ringFlag(ringFlag),
    .irqFlag(irqFlag), .errInvalid(errInvalid), .errLength(errLength)
  );
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
  parameter int MAX_CHUNK = 64,
  parameter int CHUNK_W   = $clog2(MAX_CHUNK + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               descReq,
  input logic [31:0]        descAddr,
  input logic               dataReq,
  input logic [31:0]        dataAddr,
  input logic [CHUNK_W-1:0] dataLen,
  input logic               dataAck,
  input logic               busy,
  input logic               done,
  input logic               irqPulse
);
  // R13
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataReq && !dataAck |=> dataReq && $stable(dataAddr) && $stable(dataLen));

  // R5
  chunk_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataReq |-> (dataLen != '0) && (dataLen <= CHUNK_W'(MAX_CHUNK)));

  // R6
  one_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dataReq && descReq));

  // R4
  desc_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    descReq |-> descAddr[2:0] == 3'b000);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  irq_scope_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> busy && !done && !dataReq);
endmodule

bind sg_link_walker sgw_checker #(.MAX_CHUNK(MAX_CHUNK), .CHUNK_W(CHUNK_W)) u_chk (
  .clk(clk), .rstN(rstN), .descReq(descReq), .descAddr(descAddr),
  .dataReq(dataReq), .dataAddr(dataAddr), .dataLen(dataLen),
  .dataAck(dataAck), .busy(busy), .done(done), .irqPulse(irqPulse)
);

// File: tb/sg_link_walker_test.sv
`timescale 1ns/1ps
module sg_link_walker_test;
  localparam int MAX_CHUNK = 64;
  localparam int CHUNK_W = $clog2(MAX_CHUNK + 1);
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] dataMode = 2'd0;
  logic [31:0] listBase = '0, bufAddr = '0;
  logic [23:0] bufLen = '0;
  logic descReq, dataReq, busy, done, irqPulse, errInvalid, errLength;
  logic [31:0] descAddr, dataAddr;
  logic [CHUNK_W-1:0] dataLen;
  logic [2:0] dataAction;
  logic descAck = 1'b0, dataAck = 1'b0;
  logic [63:0] descData = '0;

  always #2.5 clk = ~clk;

  sg_link_walker #(.MAX_CHUNK(MAX_CHUNK)) uut (
    .clk(clk), .rstN(rstN), .start(start), .dataMode(dataMode),
    .listBase(listBase), .bufAddr(bufAddr), .bufLen(bufLen),
    .descReq(descReq), .descAddr(descAddr), .descAck(descAck), .descData(descData),
    .dataReq(dataReq), .dataAddr(dataAddr), .dataLen(dataLen),
    .dataAction(dataAction), .dataAck(dataAck), .busy(busy), .done(done),
    .irqPulse(irqPulse), .errInvalid(errInvalid), .errLength(errLength)
  );

  int nChecks = 0, nFails = 0;
  logic [63:0] mem [0:15];
  int evCount = 0, irqCnt = 0, doneCnt = 0, stallSet = 0, dStall = 0, xStall = 0;
  int evKind [0:31];
  logic [31:0] evAddr [0:31];
  int evLen [0:31];
  int evAct [0:31];

  // memory and data port responder, log of every accepted request
  always @(negedge clk) begin
    if (!rstN) begin
      descAck = 1'b0; dataAck = 1'b0;
    end else begin
      if (irqPulse) irqCnt++;
      if (done) doneCnt++;
      if (descAck) descAck = 1'b0;
      else if (descReq) begin
        if (dStall > 0) dStall--;
        else begin
          descAck = 1'b1;
          descData = mem[4'((descAddr - BASE) >> 3)];
          if (evCount < 32) begin
            evKind[evCount] = 0; evAddr[evCount] = descAddr;
            evLen[evCount] = 0; evAct[evCount] = 0;
          end
          evCount++;
          dStall = stallSet;
        end
      end
      if (dataAck) dataAck = 1'b0;
      else if (dataReq) begin
        if (xStall > 0) xStall--;
        else begin
          dataAck = 1'b1;
          if (evCount < 32) begin
            evKind[evCount] = 1; evAddr[evCount] = dataAddr;
            evLen[evCount] = int'(dataLen); evAct[evCount] = int'(dataAction);
          end
          evCount++;
          xStall = stallSet;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkEntry(input logic [31:0] addr, input int len,
      input bit valid, input bit last, input bit irq, input int act, input bit ring);
    return {addr, 24'(len), 1'b0, ring, 3'(act), irq, last, valid};
  endfunction

  task automatic clearLog();
    evCount = 0; irqCnt = 0; doneCnt = 0; dStall = 0; xStall = 0;
  endtask

  task automatic pulseStart(input logic [1:0] m);
    @(negedge clk);
    dataMode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (doneCnt == 0 && n < 5000) begin
      @(negedge clk); n++;
    end
    check(doneCnt == 1, req, "walk ended with done", doneCnt, 1);
    @(negedge clk);
  endtask

  task automatic expEv(input int i, input int kind, input logic [31:0] addr,
                       input int len, input int act, input string req);
    if (i >= evCount) begin
      check(1'b0, req, $sformatf("event %0d missing", i), evCount, i + 1);
    end else begin
      check(evKind[i] == kind, req, $sformatf("event %0d kind", i), evKind[i], kind);
      check(evAddr[i] == addr, req, $sformatf("event %0d addr", i), evAddr[i], addr);
      if (kind == 1) begin
        check(evLen[i] == len, req, $sformatf("event %0d len", i), evLen[i], len);
        check(evAct[i] == act, req, $sformatf("event %0d action", i), evAct[i], act);
      end
    end
  endtask

  task automatic testReset();
    // R1
    check(!busy && !done && !irqPulse, "R1", "status low", {busy, done, irqPulse}, 0);
    check(!descReq && !dataReq, "R1", "requests low", {descReq, dataReq}, 0);
    check(!errInvalid && !errLength, "R1", "errors low", {errInvalid, errLength}, 0);
  endtask

  task automatic testNoMemModes();
    for (int m = 0; m < 2; m++) begin
      clearLog();
      @(negedge clk);
      dataMode = 2'(m); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b1, "R2", "done one cycle after start", done, 1);
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R2", "done single pulse, idle", {done, busy}, 0);
      check(evCount == 0, "R2", "no requests", evCount, 0);
    end
  endtask

  task automatic testFlat();
    clearLog(); stallSet = 0;
    bufAddr = 32'h2000_0010; bufLen = 24'd150;
    pulseStart(2'd2);
    waitDone("R3");
    check(evCount == 3, "R3", "event count", evCount, 3);
    expEv(0, 1, 32'h2000_0010, 64, 0, "R5");
    expEv(1, 1, 32'h2000_0050, 64, 0, "R5");
    expEv(2, 1, 32'h2000_0090, 22, 0, "R3");
  endtask

  task automatic testList();
    clearLog(); stallSet = 1;
    mem[0] = mkEntry(32'h3000, 70, 1, 0, 1, 5, 0);
    mem[1] = mkEntry(32'h4000, 0, 1, 0, 0, 0, 0);
    mem[2] = mkEntry(32'h5000, 10, 1, 1, 1, 2, 0);
    listBase = BASE + 32'd3;
    pulseStart(2'd3);
    // R14: second start while busy must change nothing
    bufAddr = 32'h7000; bufLen = 24'd8;
    pulseStart(2'd2);
    waitDone("R8");
    repeat (8) @(negedge clk);
    check(evCount == 6, "R8", "no reads after end entry", evCount, 6);
    expEv(0, 0, BASE, 0, 0, "R4");
    expEv(1, 1, 32'h3000, 64, 5, "R13");
    expEv(2, 1, 32'h3040, 6, 5, "R6");
    expEv(3, 0, BASE + 8, 0, 0, "R4");
    expEv(4, 0, BASE + 16, 0, 0, "R7");
    expEv(5, 1, 32'h5000, 10, 2, "R14");
    check(irqCnt == 2, "R12", "irq pulses", irqCnt, 2);
    check(!errInvalid && !errLength, "R8", "no error", {errInvalid, errLength}, 0);
    stallSet = 0;
  endtask

  task automatic testInvalid();
    clearLog();
    mem[0] = mkEntry(32'h6000, 8, 1, 0, 0, 1, 0);
    mem[1] = mkEntry(32'h6100, 8, 0, 1, 0, 1, 0);
    listBase = BASE;
    pulseStart(2'd3);
    waitDone("R9");
    check(evCount == 3, "R9", "no data for invalid entry", evCount, 3);
    expEv(1, 1, 32'h6000, 8, 1, "R9");
    expEv(2, 0, BASE + 8, 0, 0, "R9");
    check(errInvalid && !errLength, "R9", "invalid flag", {errInvalid, errLength}, 2);
    pulseStart(2'd0);
    @(negedge clk);
    check(!errInvalid, "R9", "flag cleared by next start", errInvalid, 0);
  endtask

  task automatic testTooLong();
    clearLog();
    mem[0] = mkEntry(32'h8000, 32'h10_0001, 1, 1, 1, 0, 0);
    listBase = BASE;
    pulseStart(2'd3);
    waitDone("R10");
    check(evCount == 1, "R10", "no data for long entry", evCount, 1);
    check(errLength && !errInvalid, "R10", "length flag", {errInvalid, errLength}, 1);
    check(irqCnt == 0, "R12", "no irq for rejected segment", irqCnt, 0);
    clearLog();
    bufAddr = 32'h9000; bufLen = 24'h10_0001;
    pulseStart(2'd2);
    waitDone("R10");
    check(evCount == 0 && errLength, "R10", "long contiguous buffer", evCount, 0);
  endtask

  task automatic testRing();
    int n = 0;
    clearLog();
    mem[0] = mkEntry(32'hA000, 4, 1, 0, 0, 3, 0);
    mem[1] = mkEntry(32'hB000, 4, 1, 1, 0, 4, 1);
    listBase = BASE;
    pulseStart(2'd3);
    while (evCount < 7 && n < 2000) begin
      @(negedge clk); n++;
    end
    expEv(3, 1, 32'hB000, 4, 4, "R11");
    expEv(4, 0, BASE, 0, 0, "R11");
    expEv(5, 1, 32'hA000, 4, 3, "R11");
    expEv(6, 0, BASE + 8, 0, 0, "R11");
    check(doneCnt == 0 && busy, "R11", "ring keeps running", doneCnt, 0);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !descReq && !dataReq, "R1", "idle after reset", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNoMemModes();
    testFlat();
    testList();
    testInvalid();
    testTooLong();
    testRing();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule